// File: doc/BRIEF.md
# Hot-Swap Fault Status Register Controller

This block keeps two 8-bit fault status registers for a four-rail hot-swap power controller. It also decides whether the power switch may be driven on. The first register (E) has one undervoltage bit and one overcurrent bit for each rail. The second register (F) has a power-good-input (PGI) fault bit and a bit that marks a change of state on the board-select input. Live fault condition flags and cool-down timer flags arrive from the sensing and timing logic. The block sets the matching bits and keeps them set until a clear source removes them.

Four sources clear the registers:
- a host write that stores zeros into chosen bits,
- a falling edge on the ON input,
- the internal supply undervoltage-lockout flag,
- a falling edge on board-select. This last source sets the change-of-state bit instead of clearing it.

A clear never removes a bit whose condition is still present or whose cool-down is still running. With autoretry off, any latched fault keeps the switch off until software or another clear source removes it. With autoretry on, the switch follows the live conditions and the latched bits are kept for inspection.

Top module: `hs_fault_ctrl`

## Requirements
- R1: While reset is asserted, fault_e and fault_f read 0 and switch_en is low.
- R2: uv_flag[i] high before a rising edge sets fault_e[i] at that edge, and oc_flag[i] sets fault_e[4+i] in the same way.
- R3: pgi_flag high before a rising edge sets fault_f[4] at that edge.
- R4: A write (wr_en high, wr_addr 0 selects fault_e, wr_addr 1 selects fault_f) clears at the next edge every bit of the selected register whose wr_data bit is 0. A 1 in wr_data leaves the bit unchanged.
- R5: A high-to-low change on on_in clears both registers at the third rising edge after on_in is first sampled low, and not earlier.
- R6: intvcc_uvlo high before a rising edge clears both registers at that edge.
- R7: A high-to-low change on bd_sel_in, with the same three-edge latency as R5, clears every bit except fault_f[6] and sets fault_f[6].
- R8: Set wins over clear: a bit whose condition is asserted in a cycle is set after that edge, whatever clear sources are active.
- R9: While oc_cool[i] is high, fault_e[4+i] is forced set. While pgi_cool is high, fault_f[4] is forced set.
- R10: autoretry_en has no effect on the contents of fault_e or fault_f.
- R11: With autoretry_en low, switch_en is low whenever any fault_e bit or fault_f[4] is set. It is high in the same cycle those bits are all clear, provided the synchronized ON level is high.
- R12: With autoretry_en high, switch_en equals the synchronized ON level gated by the absence of any live fault or cool-down flag, whatever the latched bits hold.
- R13: fault_f bits 0 to 3, 5 and 7 always read 0. fault_f[6] is cleared by a zero write, an ON falling edge or intvcc_uvlo.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uv_flag | input | 4 | Per-rail undervoltage condition |
| oc_flag | input | 4 | Per-rail overcurrent condition |
| oc_cool | input | 4 | Per-rail overcurrent cool-down running |
| pgi_flag | input | 1 | Power-good-input fault condition |
| pgi_cool | input | 1 | PGI cool-down running |
| autoretry_en | input | 1 | Autoretry mode |
| on_in | input | 1 | ON control, asynchronous |
| bd_sel_in | input | 1 | Board-select, asynchronous |
| intvcc_uvlo | input | 1 | Internal supply below lockout |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 1 | 0 = fault_e, 1 = fault_f |
| wr_data | input | 8 | Host write data |
| fault_e | output | 8 | Rail fault register |
| fault_f | output | 8 | PGI / board-select register |
| switch_en | output | 1 | Power switch enable |

## Verification
A fault condition and a clear can arrive in the same cycle. Examples are a zero write while a rail still shows undervoltage, and an ON or board-select edge arriving during an overcurrent cool-down. In each case set priority decides the outcome. The bench provokes this on purpose with directed collisions. The seeded random phase also drives rare fault pulses alongside frequent zero writes and occasional edges and lockout pulses. Each cycle is judged against a bench model built from the requirements, with the three-edge latency of the synchronized edges included.

// File: rtl/hs_fault_pkg.sv
package hs_fault_pkg;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned F_PGI_BIT = 4;
  localparam int unsigned F_BDC_BIT = 6;
  localparam logic        ADDR_E    = 1'b0;
  localparam logic        ADDR_F    = 1'b1;
endpackage

// File: rtl/hs_reset_sync.sv
module hs_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/hs_edge_fall.sv
module hs_edge_fall #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fall
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d    = sync_q;
    sync_d[0] = din;
    for (int k = 1; k < STAGES; k++) begin
      sync_d[k] = sync_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign fall  = prev_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/hs_fault_bits.sv
module hs_fault_bits #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q
);
  logic [W-1:0] bits_q;
  logic [W-1:0] bits_d;
  logic         upd_en;

  always_comb begin
    bits_d = set_vec | (bits_q & ~clr_vec);
    upd_en = (|set_vec) | (|clr_vec);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= '0;
    else if (upd_en) bits_q <= bits_d;
  end

  assign q = bits_q;
endmodule

// File: rtl/hs_switch_gate.sv
module hs_switch_gate #(
  parameter int unsigned W = 8
) (
  input  logic         on_level,
  input  logic         autoretry_en,
  input  logic [W-1:0] latched_e,
  input  logic         latched_pgi,
  input  logic [W-1:0] live_e,
  input  logic         live_pgi,
  output logic         switch_en
);
  logic hold_latched;
  logic hold_live;
  logic blocked;

  always_comb begin
    hold_latched = (|latched_e) | latched_pgi;
    hold_live    = (|live_e) | live_pgi;
    blocked      = autoretry_en ? hold_live : hold_latched;
    switch_en    = on_level & ~blocked;
  end
endmodule

// File: rtl/hs_fault_ctrl.sv
module hs_fault_ctrl
  import hs_fault_pkg::*;
#(
  parameter int unsigned NUM_RAILS   = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RAILS-1:0] uv_flag,
  input  logic [NUM_RAILS-1:0] oc_flag,
  input  logic [NUM_RAILS-1:0] oc_cool,
  input  logic                 pgi_flag,
  input  logic                 pgi_cool,
  input  logic                 autoretry_en,
  input  logic                 on_in,
  input  logic                 bd_sel_in,
  input  logic                 intvcc_uvlo,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [REG_W-1:0]     wr_data,
  output logic [REG_W-1:0]     fault_e,
  output logic [REG_W-1:0]     fault_f,
  output logic                 switch_en
);
  localparam int unsigned E_W = 2 * NUM_RAILS;

  logic             rst_sync_n;
  logic             on_level;
  logic             on_fall;
  logic             bd_level;
  logic             bd_fall;
  logic [E_W-1:0]   cond_e;
  logic             cond_pgi;
  logic             clr_global;
  logic [E_W-1:0]   e_set;
  logic [E_W-1:0]   e_clr;
  logic [REG_W-1:0] f_set;
  logic [REG_W-1:0] f_clr;
  logic [REG_W-1:0] wr_clr_e;
  logic [REG_W-1:0] wr_clr_f;
  logic [E_W-1:0]   e_q;

  hs_reset_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  hs_edge_fall #(.STAGES(SYNC_STAGES)) u_on_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (on_in),
    .level (on_level),
    .fall  (on_fall)
  );

  hs_edge_fall #(.STAGES(SYNC_STAGES)) u_bd_edge (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .din   (bd_sel_in),
    .level (bd_level),
    .fall  (bd_fall)
  );

  always_comb begin
    cond_e     = {oc_flag | oc_cool, uv_flag};
    cond_pgi   = pgi_flag | pgi_cool;
    clr_global = on_fall | intvcc_uvlo;
    wr_clr_e   = (wr_en && (wr_addr == ADDR_E)) ? ~wr_data : '0;
    wr_clr_f   = (wr_en && (wr_addr == ADDR_F)) ? ~wr_data : '0;
    e_set      = cond_e;
    e_clr      = {E_W{clr_global | bd_fall}} | wr_clr_e[E_W-1:0];
    for (int b = 0; b < REG_W; b++) begin
      if (b == F_PGI_BIT) begin
        f_set[b] = cond_pgi;
        f_clr[b] = clr_global | bd_fall | wr_clr_f[b];
      end else if (b == F_BDC_BIT) begin
        f_set[b] = bd_fall;
        f_clr[b] = clr_global | wr_clr_f[b];
      end else begin
        f_set[b] = 1'b0;
        f_clr[b] = 1'b1;
      end
    end
  end

  hs_fault_bits #(.W(E_W)) u_reg_e (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (e_set),
    .clr_vec (e_clr),
    .q       (e_q)
  );

  hs_fault_bits #(.W(REG_W)) u_reg_f (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_vec (f_set),
    .clr_vec (f_clr),
    .q       (fault_f)
  );

  generate
    if (E_W >= REG_W) begin : g_e_full
      assign fault_e = e_q[REG_W-1:0];
    end else begin : g_e_pad
      assign fault_e = {{(REG_W-E_W){1'b0}}, e_q};
    end
  endgenerate

  hs_switch_gate #(.W(E_W)) u_gate (
    .on_level     (on_level),
    .autoretry_en (autoretry_en),
    .latched_e    (e_q),
    .latched_pgi  (fault_f[F_PGI_BIT]),
    .live_e       (cond_e),
    .live_pgi     (cond_pgi),
    .switch_en    (switch_en)
  );

  logic unused_bd_level;
  assign unused_bd_level = bd_level;
endmodule

// File: rtl/hs_fault_ctrl_chk.sv
module hs_fault_ctrl_chk #(
  parameter int unsigned NR = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NR-1:0] uv_flag,
  input logic [NR-1:0] oc_flag,
  input logic [NR-1:0] oc_cool,
  input logic          pgi_flag,
  input logic          pgi_cool,
  input logic          autoretry_en,
  input logic          intvcc_uvlo,
  input logic          wr_en,
  input logic          wr_addr,
  input logic [7:0]    wr_data,
  input logic          on_fall,
  input logic          bd_fall,
  input logic [7:0]    fault_e,
  input logic [7:0]    fault_f,
  input logic          switch_en
);
  logic [2*NR-1:0] cond_e;
  assign cond_e = {oc_flag | oc_cool, uv_flag};

  assert_uv_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_flag != '0) |=> ((fault_e[NR-1:0] & $past(uv_flag)) == $past(uv_flag)));

  assert_pgi_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pgi_flag |=> fault_f[4]);

  assert_cool_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((oc_cool != '0) || pgi_cool) |=>
      (((fault_e[2*NR-1:NR] & $past(oc_cool)) == $past(oc_cool)) &&
       (fault_f[4] || !$past(pgi_cool))));

  assert_uvlo_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (intvcc_uvlo && cond_e == '0 && !pgi_flag && !pgi_cool) |=>
      (fault_e == '0 && (fault_f & 8'hBF) == '0));

  assert_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_addr && !on_fall && !bd_fall && !intvcc_uvlo) |=>
      ((($past(fault_e & wr_data)) & ~fault_e) == '0 &&
       (fault_e & $past(~wr_data & {{(8-2*NR){1'b0}}, ~cond_e})) == '0));

  assert_bdsel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bd_fall |=> fault_f[6]);

  assert_spare_zero_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_f & 8'hAF) == '0);

  assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!autoretry_en && ((fault_e != '0) || fault_f[4])) |-> !switch_en);
endmodule

bind hs_fault_ctrl hs_fault_ctrl_chk #(.NR(NUM_RAILS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .uv_flag      (uv_flag),
  .oc_flag      (oc_flag),
  .oc_cool      (oc_cool),
  .pgi_flag     (pgi_flag),
  .pgi_cool     (pgi_cool),
  .autoretry_en (autoretry_en),
  .intvcc_uvlo  (intvcc_uvlo),
  .wr_en        (wr_en),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data),
  .on_fall      (on_fall),
  .bd_fall      (bd_fall),
  .fault_e      (fault_e),
  .fault_f      (fault_f),
  .switch_en    (switch_en)
);

// File: tb/hs_fault_ctrl_tb.sv
module hs_fault_ctrl_tb;
  logic       clk;
  logic       rst_n;
  logic [3:0] uv_flag, oc_flag, oc_cool;
  logic       pgi_flag, pgi_cool, autoretry_en, on_in, bd_sel_in, intvcc_uvlo;
  logic       wr_en, wr_addr;
  logic [7:0] wr_data;
  logic [7:0] fault_e, fault_f;
  logic       switch_en;

  int unsigned total = 0;
  int unsigned bad   = 0;

  logic [7:0] m_e, m_f;
  logic       m_on1, m_on2, m_on3, m_bd1, m_bd2, m_bd3;

  hs_fault_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .uv_flag(uv_flag), .oc_flag(oc_flag),
    .oc_cool(oc_cool), .pgi_flag(pgi_flag), .pgi_cool(pgi_cool),
    .autoretry_en(autoretry_en), .on_in(on_in), .bd_sel_in(bd_sel_in),
    .intvcc_uvlo(intvcc_uvlo), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_e(fault_e), .fault_f(fault_f),
    .switch_en(switch_en)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] nxt_e(input logic [7:0] e, input logic [3:0] uv,
      input logic [3:0] oc, input logic [3:0] occ, input logic clr_all,
      input logic [7:0] wclr);
    return {oc | occ, uv} | (e & ~({8{clr_all}} | wclr));
  endfunction

  function automatic logic [7:0] nxt_f(input logic [7:0] f, input logic pgi,
      input logic clr_g, input logic bdf, input logic [7:0] wclr);
    logic [7:0] r;
    r    = 8'h00;
    r[4] = pgi | (f[4] & ~(clr_g | bdf | wclr[4]));
    r[6] = bdf | (f[6] & ~(clr_g | wclr[6]));
    return r;
  endfunction

  function automatic logic exp_sw(input logic onl, input logic ar, input logic [7:0] e,
      input logic [7:0] f, input logic live);
    return onl & ~(ar ? live : ((|e) | f[4]));
  endfunction

  // Called just after a falling edge with inputs already driven.
  task automatic cycle();
    logic       live, on_f, bd_f;
    logic [7:0] wce, wcf;
    #2;
    live = (|uv_flag) | (|oc_flag) | (|oc_cool) | pgi_flag | pgi_cool;
    chk(autoretry_en ? "R12 switch" : "R11 switch", switch_en,
        exp_sw(m_on2, autoretry_en, m_e, m_f, live));
    on_f = m_on3 & ~m_on2;
    bd_f = m_bd3 & ~m_bd2;
    wce  = (wr_en && !wr_addr) ? ~wr_data : 8'h00;
    wcf  = (wr_en &&  wr_addr) ? ~wr_data : 8'h00;
    m_e  = nxt_e(m_e, uv_flag, oc_flag, oc_cool, on_f | intvcc_uvlo | bd_f, wce);
    m_f  = nxt_f(m_f, pgi_flag | pgi_cool, on_f | intvcc_uvlo, bd_f, wcf);
    m_on3 = m_on2; m_on2 = m_on1; m_on1 = on_in;
    m_bd3 = m_bd2; m_bd2 = m_bd1; m_bd1 = bd_sel_in;
    @(posedge clk);
    @(negedge clk);
    chk("R2 model fault_e", fault_e, m_e);
    chk("R3 model fault_f", fault_f, m_f);
  endtask

  task automatic quiet();
    uv_flag = '0; oc_flag = '0; oc_cool = '0; pgi_flag = 0; pgi_cool = 0;
    intvcc_uvlo = 0; wr_en = 0; wr_addr = 0; wr_data = 8'h00;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      quiet();
      cycle();
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    quiet();
    wr_en = 1; wr_addr = a; wr_data = d;
    cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 0; quiet(); autoretry_en = 0; on_in = 0; bd_sel_in = 0;
    m_e = 0; m_f = 0;
    {m_on1, m_on2, m_on3, m_bd1, m_bd2, m_bd3} = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset fault_e", fault_e, 8'h00);
    chk("R1 reset fault_f", fault_f, 8'h00);
    chk("R1 reset switch_en", switch_en, 1'b0);
    rst_n = 1;
    idle(4);

    on_in = 1; idle(3);
    chk("R11 switch on when clean", switch_en, 1'b1);

    // R2 undervoltage and overcurrent set
    quiet(); uv_flag = 4'b0100; cycle();
    chk("R2 uv rail2", fault_e, 8'h04);
    quiet(); oc_flag = 4'b1000; cycle();
    chk("R2 oc rail3", fault_e, 8'h84);
    #2 chk("R11 switch held off", switch_en, 1'b0);

    // R4 writing ones keeps, zeros clear
    wr(1'b0, 8'hFF);
    chk("R4 write ones no change", fault_e, 8'h84);
    wr(1'b0, 8'h7F);
    chk("R4 write zero clears bit7", fault_e, 8'h04);

    // R8 set wins over zero write
    quiet(); uv_flag = 4'b0001; wr_en = 1; wr_addr = 0; wr_data = 8'h00; cycle();
    chk("R8 set beats write clear", fault_e, 8'h01);
    wr(1'b0, 8'h00);
    chk("R4 full clear", fault_e, 8'h00);
    #2 chk("R11 switch back on", switch_en, 1'b1);

    // R9 cool-down forces overcurrent bit
    quiet(); oc_flag = 4'b0010; oc_cool = 4'b0010; cycle();
    quiet(); oc_cool = 4'b0010; wr_en = 1; wr_data = 8'h00; cycle();
    chk("R9 cool-down blocks clear", fault_e, 8'h20);
    wr(1'b0, 8'h00);
    chk("R9 clear after cool-down", fault_e, 8'h00);

    // R3 PGI, R10 autoretry does not clear, R12 live gating
    quiet(); pgi_flag = 1; cycle();
    chk("R3 pgi set", fault_f, 8'h10);
    quiet(); autoretry_en = 1; cycle(); idle(2);
    chk("R10 autoretry keeps fault_f", fault_f, 8'h10);
    #2 chk("R12 switch on with latched bit", switch_en, 1'b1);
    quiet(); pgi_cool = 1; #2 chk("R12 switch off on live cool", switch_en, 1'b0);
    cycle();
    autoretry_en = 0; idle(1);

    // R5 ON falling edge
    on_in = 0; idle(2);
    chk("R5 not yet cleared", fault_f, 8'h10);
    idle(1);
    chk("R5 cleared after third edge", fault_f, 8'h00);
    on_in = 1; idle(3);

    // R7 board-select falling edge
    quiet(); uv_flag = 4'b1000; cycle();
    bd_sel_in = 1; idle(4);
    bd_sel_in = 0; idle(3);
    chk("R7 fault_e cleared", fault_e, 8'h00);
    chk("R7 change bit set", fault_f, 8'h40);
    wr(1'b1, 8'hFF);
    chk("R13 write ones keeps F6", fault_f, 8'h40);
    wr(1'b1, 8'hBF);
    chk("R13 zero write clears F6", fault_f, 8'h00);

    // R6 lockout
    quiet(); uv_flag = 4'b0011; cycle();
    quiet(); intvcc_uvlo = 1; cycle();
    chk("R6 lockout clear", fault_e, 8'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      quiet();
      for (int b = 0; b < 4; b++) begin
        uv_flag[b] = ($urandom % 24) == 0;
        oc_flag[b] = ($urandom % 24) == 0;
        oc_cool[b] = ($urandom % 20) == 0;
      end
      pgi_flag    = ($urandom % 24) == 0;
      pgi_cool    = ($urandom % 20) == 0;
      intvcc_uvlo = ($urandom % 60) == 0;
      if (($urandom % 4) == 0) begin
        wr_en = 1; wr_addr = 1'($urandom); wr_data = 8'($urandom);
      end
      if (($urandom % 40) == 0) on_in = ~on_in;
      if (($urandom % 40) == 0) bd_sel_in = ~bd_sel_in;
      if (($urandom % 100) == 0) autoretry_en = ~autoretry_en;
      cycle();
      chk("R13 spare bits zero", fault_f & 8'hAF, 8'h00);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule